// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key-Sequence Service

This block is a watchdog timer on a simple 32-bit register bus. Before it is armed, software sets a coarse 12-bit reload value, chooses how large the open service window is, and chooses whether a violation raises a non-maskable interrupt or a reset. Writing one specific 32-bit word to the control register arms the block. Once armed, nothing short of a system reset can disarm it, and the configuration registers become read-only.

An armed watchdog counts down from the scaled reload value. Software services it by writing two key words in order. The service is only legal while the count lies inside the open window, which is the final fraction of the period before expiry. Two things count as a violation: finishing the key sequence before the window opens, and letting the count reach zero. A violation reloads the counter, sets a sticky status flag and emits a one-cycle pulse on the selected reaction output.

Top module: `win_watchdog`

## Requirements
- R1: After reset the block is disarmed and holds its counter at 0. The status flag is clear and both reaction outputs are low. Control reads 0, reaction reads 0 and window reads 0x50.
- R2: Only a write of exactly 0xA98559DA to control (offset 0x00) arms the block; any other control write changes nothing. While armed, control reads back 0xA98559DA, and no later control write disarms it.
- R3: Arming loads the counter with the preload field (offset 0x04, bits [11:0]) shifted left by PRE_SHIFT. The counter then drops by one on every clock and can be read at offset 0x10.
- R4: The window register is at offset 0x18. Codes 0x50, 0x500, 0x5000, 0x50000 and 0x500000 give an open window of reload>>k, with k = 1..5 respectively. Any other code acts as 0x50. A read returns the code in effect.
- R5: A service is a write of 0xE51A followed by a write of 0xA35C to the key register (offset 0x0C). If the counter is at or below the window threshold when the service completes, the counter reloads on the next edge and no violation occurs.
- R6: A key write of any value other than the two keys, or a 0xA35C write with no 0xE51A before it, does not reload the counter and resets the sequence. After that, a lone 0xA35C does not service.
- R7: If a service completes while the counter is above the threshold, it is a violation. The counter still reloads.
- R8: If the counter is 0 on an edge with no service, it is a violation, and the counter reloads.
- R9: If the reaction register (offset 0x14) was written with 0xA, a violation pulses nmi_o; any other value selects rst_o. The pulse is high for exactly the one cycle after the detecting edge. The reaction register reads 0xA or 0.
- R10: Status bit 1 (offset 0x08) is set by a violation and cleared by writing 1 to it. A violation takes precedence over a clear in the same cycle.
- R11: While armed, writes to the preload, window and reaction registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| nmi_o | output | 1 | Violation pulse when the interrupt reaction is selected |
| rst_o | output | 1 | Violation pulse when the reset reaction is selected |

## Verification
The assertions take for granted that a write lasts one cycle, with the address and data steady for that cycle. They also assume the preload is non-zero once armed, because a zero reload makes every cycle a violation. The stimulus issues writes one at a time with idle cycles between them and always sets a non-zero preload before arming. It places key writes relative to the count, some before the window opens and some inside it. A second run after reset covers the reset reaction and an unlisted window code.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam logic [31:0] ARM_WORD  = 32'hA98559DA;
  localparam logic [31:0] KEY_OPEN  = 32'h0000E51A;
  localparam logic [31:0] KEY_CLOSE = 32'h0000A35C;
  localparam logic [31:0] REACT_NMI = 32'h0000000A;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_PRE   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_KEY   = 8'h0C;
  localparam logic [7:0] OFF_CNT   = 8'h10;
  localparam logic [7:0] OFF_REACT = 8'h14;
  localparam logic [7:0] OFF_WIN   = 8'h18;

  typedef enum logic {SEQ_ACTIVE, SEQ_SERVICE} seq_e;

  // Window code to right-shift amount; unknown codes fall back to half.
  function automatic logic [2:0] win_decode(input logic [31:0] code);
    case (code)
      32'h0000_0050: win_decode = 3'd1;
      32'h0000_0500: win_decode = 3'd2;
      32'h0000_5000: win_decode = 3'd3;
      32'h0005_0000: win_decode = 3'd4;
      32'h0050_0000: win_decode = 3'd5;
      default:       win_decode = 3'd1;
    endcase
  endfunction

  // Canonical code for a shift amount: nibble 5 placed at position k.
  function automatic logic [31:0] win_encode(input logic [2:0] k);
    win_encode = 32'h5 << (4 * k);
  endfunction

endpackage

// File: rtl/wwd_keyfsm.sv
module wwd_keyfsm
  import wwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  output logic        svc_done
);

  seq_e seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SEQ_ACTIVE;
    end else if (!armed) begin
      seq_q <= SEQ_ACTIVE;
    end else if (key_wr) begin
      seq_q <= (key_val == KEY_OPEN) ? SEQ_SERVICE : SEQ_ACTIVE;
    end
  end

  assign svc_done = armed && key_wr && (key_val == KEY_CLOSE) &&
                    (seq_q == SEQ_SERVICE);

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int PRE_W     = 12,
  parameter int PRE_SHIFT = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         arm_req,
  input  logic [PRE_W-1:0]             pre_q,
  input  logic [2:0]                   win_k,
  input  logic                         svc_done,
  output logic                         armed,
  output logic [PRE_W+PRE_SHIFT-1:0]   cnt,
  output logic                         win_open,
  output logic                         viol
);

  localparam int CNT_W = PRE_W + PRE_SHIFT;

  function automatic logic [CNT_W-1:0] load_value(input logic [PRE_W-1:0] p);
    load_value = {p, {PRE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [CNT_W-1:0] win_threshold(input logic [CNT_W-1:0] r,
                                                     input logic [2:0] k);
    win_threshold = r >> k;
  endfunction

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] thresh;
  logic             expire;

  assign reload   = load_value(pre_q);
  assign thresh   = win_threshold(reload, win_k);
  assign win_open = (cnt <= thresh);
  assign expire   = armed && !svc_done && (cnt == '0);
  assign viol     = expire || (svc_done && !win_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!armed) begin
      if (arm_req) begin
        armed <= 1'b1;
        cnt   <= reload;
      end
    end else if (svc_done || cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int PRE_W  = 12,
  parameter int CNT_W  = 25,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              armed,
  input  logic              viol,
  input  logic [CNT_W-1:0]  cnt,
  output logic [PRE_W-1:0]  pre_q,
  output logic [2:0]        win_k,
  output logic              nmi_sel,
  output logic              stat_q,
  output logic              arm_req,
  output logic [31:0]       bus_rdata
);

  logic hit_ctrl, hit_pre, hit_stat, hit_react, hit_win;

  assign hit_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_pre   = bus_wr && (bus_addr == ADDR_W'(OFF_PRE));
  assign hit_stat  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_react = bus_wr && (bus_addr == ADDR_W'(OFF_REACT));
  assign hit_win   = bus_wr && (bus_addr == ADDR_W'(OFF_WIN));

  assign arm_req = hit_ctrl && !armed && (bus_wdata == ARM_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      win_k   <= 3'd1;
      nmi_sel <= 1'b0;
    end else if (!armed) begin
      if (hit_pre)   pre_q   <= bus_wdata[PRE_W-1:0];
      if (hit_win)   win_k   <= win_decode(bus_wdata);
      if (hit_react) nmi_sel <= (bus_wdata == REACT_NMI);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (viol) begin
      stat_q <= 1'b1;
    end else if (hit_stat && bus_wdata[1]) begin
      stat_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  bus_rdata = armed ? ARM_WORD : '0;
      ADDR_W'(OFF_PRE):   bus_rdata = 32'(pre_q);
      ADDR_W'(OFF_STAT):  bus_rdata = {30'b0, stat_q, 1'b0};
      ADDR_W'(OFF_CNT):   bus_rdata = 32'(cnt);
      ADDR_W'(OFF_REACT): bus_rdata = nmi_sel ? REACT_NMI : '0;
      ADDR_W'(OFF_WIN):   bus_rdata = win_encode(win_k);
      default:            bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int PRE_W     = 12,
  parameter int PRE_SHIFT = 13,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              nmi_o,
  output logic              rst_o
);

  localparam int CNT_W = PRE_W + PRE_SHIFT;

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             win_open;
  logic             viol;
  logic             svc_done;
  logic             key_wr;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       win_k;
  logic             nmi_sel;
  logic             stat_q;
  logic             arm_req;

  assign key_wr = bus_wr && (bus_addr == ADDR_W'(OFF_KEY));

  wwd_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .armed(armed), .viol(viol), .cnt(cnt),
    .pre_q(pre_q), .win_k(win_k), .nmi_sel(nmi_sel), .stat_q(stat_q),
    .arm_req(arm_req), .bus_rdata(bus_rdata)
  );

  wwd_keyfsm u_keyfsm (
    .clk(clk), .rst_n(rst_n), .armed(armed), .key_wr(key_wr),
    .key_val(bus_wdata), .svc_done(svc_done)
  );

  wwd_counter #(.PRE_W(PRE_W), .PRE_SHIFT(PRE_SHIFT)) u_counter (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .pre_q(pre_q),
    .win_k(win_k), .svc_done(svc_done), .armed(armed), .cnt(cnt),
    .win_open(win_open), .viol(viol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_o <= 1'b0;
      rst_o <= 1'b0;
    end else begin
      nmi_o <= viol && nmi_sel;
      rst_o <= viol && !nmi_sel;
    end
  end

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int CNT_W = 25,
  parameter int PRE_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             win_open,
  input logic             svc_done,
  input logic             viol,
  input logic             nmi_o,
  input logic             rst_o,
  input logic             stat_q,
  input logic [PRE_W-1:0] pre_q
);

  assert_armed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !svc_done && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_good_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && win_open) |-> !viol);

  assert_reload_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (svc_done || cnt == '0)) |=>
      (cnt == {pre_q, {(CNT_W-PRE_W){1'b0}}}));

  assert_early_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && !win_open) |-> viol);

  assert_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !svc_done && cnt == '0) |-> viol);

  assert_reaction_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (nmi_o || rst_o));

  assert_no_spurious_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |=> !(nmi_o || rst_o));

  assert_one_reaction_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_o && rst_o));

  assert_status_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> stat_q);

  assert_config_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(pre_q));

endmodule

bind win_watchdog wwd_checker #(.CNT_W(PRE_W + PRE_SHIFT), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .cnt(cnt), .win_open(win_open),
  .svc_done(svc_done), .viol(viol), .nmi_o(nmi_o), .rst_o(rst_o),
  .stat_q(stat_q), .pre_q(pre_q)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;

  localparam int SH = 6;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL  = 5'h00;
  localparam logic [AW-1:0] A_PRE   = 5'h04;
  localparam logic [AW-1:0] A_STAT  = 5'h08;
  localparam logic [AW-1:0] A_KEY   = 5'h0C;
  localparam logic [AW-1:0] A_CNT   = 5'h10;
  localparam logic [AW-1:0] A_REACT = 5'h14;
  localparam logic [AW-1:0] A_WIN   = 5'h18;
  localparam logic [AW-1:0] A_NONE  = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = A_CNT;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          nmi_o, rst_o;

  win_watchdog #(.PRE_W(12), .PRE_SHIFT(SH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_o(nmi_o), .rst_o(rst_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur = "R1";

  // Behavioural reference model
  int m_armed, m_cnt, m_pre, m_k, m_nmisel, m_svc, m_stat, m_nmi, m_rst;
  int t_rl, t_thr, t_v, t_kw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_cnt = 0; m_pre = 0; m_k = 1; m_nmisel = 0;
      m_svc = 0; m_stat = 0; m_nmi = 0; m_rst = 0;
    end else begin
      t_rl  = m_pre * (1 << SH);
      t_thr = t_rl / (1 << m_k);
      t_v   = 0;
      t_kw  = (bus_wr && bus_addr == A_KEY) ? 1 : 0;
      if (m_armed != 0) begin
        if (t_kw != 0 && bus_wdata == 32'hA35C && m_svc != 0) begin
          t_v = (m_cnt > t_thr) ? 1 : 0;
          m_cnt = t_rl;
        end else if (m_cnt == 0) begin
          t_v = 1;
          m_cnt = t_rl;
        end else begin
          m_cnt = m_cnt - 1;
        end
        if (t_kw != 0) m_svc = (bus_wdata == 32'hE51A) ? 1 : 0;
      end else if (bus_wr) begin
        if (bus_addr == A_CTRL && bus_wdata == 32'hA98559DA) begin
          m_armed = 1;
          m_cnt = t_rl;
        end
        if (bus_addr == A_PRE) m_pre = int'(bus_wdata[11:0]);
        if (bus_addr == A_REACT) m_nmisel = (bus_wdata == 32'hA) ? 1 : 0;
        if (bus_addr == A_WIN) begin
          if      (bus_wdata == 32'h500)    m_k = 2;
          else if (bus_wdata == 32'h5000)   m_k = 3;
          else if (bus_wdata == 32'h50000)  m_k = 4;
          else if (bus_wdata == 32'h500000) m_k = 5;
          else                              m_k = 1;
        end
      end
      if (t_v != 0) m_stat = 1;
      else if (bus_wr && bus_addr == A_STAT && bus_wdata[1]) m_stat = 0;
      m_nmi = (t_v != 0 && m_nmisel != 0) ? 1 : 0;
      m_rst = (t_v != 0 && m_nmisel == 0) ? 1 : 0;
    end
  end

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (a)
      A_CTRL:  return (m_armed != 0) ? 32'hA98559DA : 32'h0;
      A_PRE:   return 32'(m_pre);
      A_STAT:  return (m_stat != 0) ? 32'h2 : 32'h0;
      A_CNT:   return 32'(m_cnt);
      A_REACT: return (m_nmisel != 0) ? 32'hA : 32'h0;
      A_WIN:   return 32'h5 << (4 * m_k);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", cur, what, got, exp, cyc);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    check("nmi_o", 32'(nmi_o), 32'(m_nmi));
    check("rst_o", 32'(rst_o), 32'(m_rst));
    if (!bus_wr) check("rdata", bus_rdata, model_read(bus_addr));
  end

  int saw_nmi = 0;
  int saw_rst = 0;
  always @(negedge clk) begin
    if (nmi_o) saw_nmi++;
    if (rst_o) saw_rst++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog %s actual=timeout expected=finish", cur);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic put(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    put(1'b1, a, d);
    put(1'b0, A_CNT, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    put(1'b0, a, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, A_CNT, '0);
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  initial begin
    // R1: reset values
    cur = "R1";
    idle(3);
    #1 rst_n = 1'b1;
    rd(A_CTRL); rd(A_REACT); rd(A_WIN); rd(A_STAT); rd(A_CNT); rd(A_NONE);
    idle(3);

    // R2: wrong arm word
    cur = "R2";
    wr(A_CTRL, 32'h12345678);
    rd(A_CTRL); idle(4);

    // R4 / R9: configuration and readback
    cur = "R4";
    wr(A_PRE, 32'h0000_F002);
    wr(A_WIN, 32'h500);
    rd(A_WIN); rd(A_PRE);
    cur = "R9";
    wr(A_REACT, 32'hA);
    rd(A_REACT);

    // R3: arm and count
    cur = "R3";
    wr(A_CTRL, 32'hA98559DA);
    rd(A_CTRL); idle(10);

    // R11: configuration frozen while armed
    cur = "R11";
    wr(A_PRE, 32'h5);
    wr(A_WIN, 32'h50);
    wr(A_REACT, 32'h3);
    rd(A_PRE); rd(A_WIN); rd(A_REACT);

    // R5: service inside the window
    cur = "R5";
    saw_nmi = 0;
    wait_cnt(20);
    wr(A_KEY, 32'hE51A);
    wr(A_KEY, 32'hA35C);
    idle(4);
    check("R5 no pulse after good service", 32'(saw_nmi), 32'd0);

    // R7: early service
    cur = "R7";
    wr(A_KEY, 32'hE51A);
    wr(A_KEY, 32'hA35C);
    idle(3);
    check("R7 early service pulse count", 32'(saw_nmi), 32'd1);

    // R10: status set, then write-1 clear
    cur = "R10";
    rd(A_STAT);
    wr(A_STAT, 32'h1);
    rd(A_STAT);
    wr(A_STAT, 32'h2);
    rd(A_STAT);

    // R6: broken sequences
    cur = "R6";
    wait_cnt(30);
    wr(A_KEY, 32'hE51A);
    wr(A_KEY, 32'h1234);
    wr(A_KEY, 32'hA35C);
    idle(2);
    wr(A_KEY, 32'hA35C);
    idle(2);

    // R8: expiry
    cur = "R8";
    saw_nmi = 0;
    wait_cnt(2);
    idle(5);
    check("R8 expiry pulse count", 32'(saw_nmi), 32'd1);
    rd(A_STAT);

    // R2: cannot disarm
    cur = "R2";
    wr(A_CTRL, 32'h0);
    rd(A_CTRL); idle(3);

    // Second run: reset reaction, unlisted window code
    cur = "R1";
    put(1'b0, A_CNT, '0);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    rd(A_CTRL); rd(A_WIN);
    cur = "R4";
    wr(A_WIN, 32'h7);
    rd(A_WIN);
    wr(A_PRE, 32'h1);
    cur = "R9";
    wr(A_REACT, 32'h3);
    rd(A_REACT);
    wr(A_CTRL, 32'hA98559DA);
    saw_rst = 0; saw_nmi = 0;
    idle(80);
    check("R9 reset pulse count", 32'(saw_rst), 32'd1);
    check("R9 no nmi when reset chosen", 32'(saw_nmi), 32'd0);

    // R4: smallest window with reload 64, threshold 2
    cur = "R4";
    put(1'b0, A_CNT, '0);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    wr(A_PRE, 32'h1);
    wr(A_WIN, 32'h500000);
    rd(A_WIN);
    wr(A_CTRL, 32'hA98559DA);
    saw_rst = 0;
    wait_cnt(6);
    wr(A_KEY, 32'hE51A);
    wr(A_KEY, 32'hA35C);
    idle(3);
    check("R4 service above 3.125% threshold is early", 32'(saw_rst), 32'd1);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule